// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block moves a byte plus one parity bit between two identical ports, A and B, in both directions at once. Each direction has its own holding register. The register loads on any clock edge where its load enable is high, and it keeps its contents while the enable is low. The held byte goes to the opposite port. The parity bit sent with it is one of two values: a freshly generated bit, or the incoming parity bit passed through unchanged. A parity-sense input selects even or odd parity, and this setting applies to generation and checking alike.

Each port has an active-low error flag that checks the nine held bits of its own direction against the selected sense. The flag keeps working when the output drivers are off. Port tri-state is modelled as a data output plus a separate drive-enable output, controlled by an active-low output enable per port. All state is clocked by a system clock and cleared by a synchronous active-low reset. The block contains no real latches.

Top module: `pxv_latched_xcvr`

## Requirements
- R1: After a clock edge with rst_n low, both holding registers are all zero. With even sense and generated parity, both data outputs and both parity outputs read 0, and both error flags read 1.
- R2: On a clock edge with a load enable high, the matching holding register captures its port's byte and parity bit. The byte appears on the opposite port's data output from that edge onward. Load enable le_a loads the A-side register, which drives B. Load enable le_b loads the B-side register, which drives A.
- R3: While a load enable is low, the opposite port's data output keeps its value, whatever happens on the input.
- R4: With par_feed = 0, the parity output is chosen so that the eight data bits plus the parity bit hold an even number of ones when odd_mode = 0, and an odd number when odd_mode = 1.
- R5: With par_feed = 1, the parity output equals the parity bit that was captured with the byte.
- R6: err_a_n and err_b_n read 0 when the nine held bits of the A-side or B-side register disagree with the selected sense, and 1 otherwise. This holds whatever the output enables are set to.
- R7: A port's drive output is 1 exactly when its active-low output enable is 0.
- R8: Loading one direction leaves the other direction's held data, parity and error flag unchanged.
- R9: A change of odd_mode or par_feed takes effect on the parity and error outputs in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| le_a | input | 1 | Load enable for the A-side register (A to B) |
| le_b | input | 1 | Load enable for the B-side register (B to A) |
| par_feed | input | 1 | 1: pass the captured parity through; 0: generate parity |
| odd_mode | input | 1 | Parity sense: 1 odd, 0 even |
| oe_a_n | input | 1 | Active-low output enable for port A |
| oe_b_n | input | 1 | Active-low output enable for port B |
| a_din | input | 8 | Byte arriving on port A |
| a_par_in | input | 1 | Parity bit arriving on port A |
| b_din | input | 8 | Byte arriving on port B |
| b_par_in | input | 1 | Parity bit arriving on port B |
| a_dout | output | 8 | Byte driven onto port A (from the B-side register) |
| a_par_out | output | 1 | Parity driven onto port A |
| a_drive | output | 1 | Drive enable for port A |
| b_dout | output | 8 | Byte driven onto port B (from the A-side register) |
| b_par_out | output | 1 | Parity driven onto port B |
| b_drive | output | 1 | Drive enable for port B |
| err_a_n | output | 1 | Active-low parity error for the A-side register |
| err_b_n | output | 1 | Active-low parity error for the B-side register |

## Verification
All of the block's state sits in the two holding registers, and every register bit reaches a port combinationally. A held byte that is wrong therefore shows on the opposite data output at the first sample after the faulty edge. A wrong held parity bit shows on the error flag at once, and on the parity output whenever pass-through is selected. The bench compares every output against a reference model once per cycle. It mixes random load, sense, select and enable patterns with directed cases: holding, cross-direction isolation, checking with drivers off, and changes of sense without a clock. A corrupted capture or a wrong sense is therefore reported within one cycle.

// File: rtl/par_xcvr_pkg.sv
// Package: shared widths and the parity-sense encoding for the transceiver.
// Assumes a single data-byte width shared by both directions.
package par_xcvr_pkg;
    parameter int unsigned PXV_DATA_W = 8;
    localparam int unsigned PXV_WORD_W = PXV_DATA_W + 1;

    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } sense_e;
endpackage

// File: rtl/pxv_hold_reg.sv
// Module: pxv_hold_reg
// Clocked stand-in for a transparent latch: it loads d on any edge with
// ld high and keeps its contents otherwise. Assumes synchronous active-low
// reset to all zeros.
module pxv_hold_reg #(
    parameter int unsigned WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture on load, clear on reset, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    // R2: a load edge makes the stored word equal the input at that edge
    p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld) |=> (q == $past(d)));

    // R3: with load low the stored word stays put
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld) |=> $stable(q));
endmodule

// File: rtl/pxv_parity_unit.sv
// Module: pxv_parity_unit
// Combinational parity logic for one held word: produces the bit that
// completes the selected sense and flags a mismatch (active low) on the
// stored data plus stored parity. Assumes sense applies to all nine bits.
module pxv_parity_unit
    import par_xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = PXV_DATA_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    input  sense_e            sense,
    output logic              gen_bit,
    output logic              ok_n_err
);
    logic data_xor;

    // Reduce data, derive completion bit and the check result.
    always_comb begin
        data_xor = ^data;
        gen_bit  = data_xor ^ sense;
        ok_n_err = ~((data_xor ^ par) ^ sense);
    end
endmodule

// File: rtl/pxv_direction.sv
// Module: pxv_direction
// One transfer path: holding register, parity unit and output select for
// the far port. Assumes the far port's drive is controlled by oe_n.
module pxv_direction
    import par_xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = PXV_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] din,
    input  logic              pin,
    input  logic              feed,
    input  logic              odd_mode,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              pout,
    output logic              drive,
    output logic              err_n
);
    localparam int unsigned WORD_W = DATA_W + 1;

    logic [WORD_W-1:0] held;
    logic              gen_bit;
    sense_e            sense;

    // Map the sense input onto the package encoding.
    always_comb sense = odd_mode ? SENSE_ODD : SENSE_EVEN;

    pxv_hold_reg #(.WIDTH(WORD_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld),
        .d     ({din, pin}),
        .q     (held)
    );

    pxv_parity_unit #(.DATA_W(DATA_W)) u_par (
        .data     (held[WORD_W-1:1]),
        .par      (held[0]),
        .sense    (sense),
        .gen_bit  (gen_bit),
        .ok_n_err (err_n)
    );

    // Drive the far port: held byte, selected parity, drive enable.
    always_comb begin
        dout  = held[WORD_W-1:1];
        pout  = feed ? held[0] : gen_bit;
        drive = ~oe_n;
    end

    // R4: generated parity completes the selected sense
    p_gen_sense_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!feed) |-> ((^{dout, pout}) == odd_mode));

    // R5: pass-through parity equals the bit loaded at the last load edge
    p_feed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && $past(ld) && $past(rst_n)) |-> (pout == $past(pin)));
endmodule

// File: rtl/pxv_latched_xcvr.sv
// Module: pxv_latched_xcvr
// Top: two mirrored transfer paths. The A-side register carries A to B and
// is checked by err_a_n; the B-side register carries B to A and is
// checked by err_b_n. Assumes one shared clock and synchronous reset.
module pxv_latched_xcvr
    import par_xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = PXV_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le_a,
    input  logic              le_b,
    input  logic              par_feed,
    input  logic              odd_mode,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  logic [DATA_W-1:0] a_din,
    input  logic              a_par_in,
    input  logic [DATA_W-1:0] b_din,
    input  logic              b_par_in,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_par_out,
    output logic              a_drive,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_par_out,
    output logic              b_drive,
    output logic              err_a_n,
    output logic              err_b_n
);
    // A to B path.
    pxv_direction #(.DATA_W(DATA_W)) u_a2b (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (le_a),
        .din      (a_din),
        .pin      (a_par_in),
        .feed     (par_feed),
        .odd_mode (odd_mode),
        .oe_n     (oe_b_n),
        .dout     (b_dout),
        .pout     (b_par_out),
        .drive    (b_drive),
        .err_n    (err_a_n)
    );

    // B to A path.
    pxv_direction #(.DATA_W(DATA_W)) u_b2a (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (le_b),
        .din      (b_din),
        .pin      (b_par_in),
        .feed     (par_feed),
        .odd_mode (odd_mode),
        .oe_n     (oe_a_n),
        .dout     (a_dout),
        .pout     (a_par_out),
        .drive    (a_drive),
        .err_n    (err_b_n)
    );

    // R6: in pass-through, the A-side flag agrees with what B carries
    p_err_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        par_feed |-> (err_a_n == ((^{b_dout, b_par_out}) == odd_mode)));

    // R6: same relation for the B-side flag seen on port A
    p_err_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        par_feed |-> (err_b_n == ((^{a_dout, a_par_out}) == odd_mode)));
endmodule

// File: tb/test_pxv_latched_xcvr.sv
module test_pxv_latched_xcvr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       le_a = 0, le_b = 0, par_feed = 0, odd_mode = 0;
    logic       oe_a_n = 1, oe_b_n = 1;
    logic [7:0] a_din = 0, b_din = 0;
    logic       a_par_in = 0, b_par_in = 0;
    logic [7:0] a_dout, b_dout;
    logic       a_par_out, b_par_out, a_drive, b_drive, err_a_n, err_b_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model of the two held words
    logic [7:0] ma_d = 0, mb_d = 0;
    logic       ma_p = 0, mb_p = 0;

    always #2.5 clk = ~clk;

    pxv_latched_xcvr i_pxv_latched_xcvr (
        .clk(clk), .rst_n(rst_n), .le_a(le_a), .le_b(le_b),
        .par_feed(par_feed), .odd_mode(odd_mode),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .a_din(a_din), .a_par_in(a_par_in), .b_din(b_din), .b_par_in(b_par_in),
        .a_dout(a_dout), .a_par_out(a_par_out), .a_drive(a_drive),
        .b_dout(b_dout), .b_par_out(b_par_out), .b_drive(b_drive),
        .err_a_n(err_a_n), .err_b_n(err_b_n)
    );

    function automatic logic gen_exp(logic [7:0] d, logic odd);
        return ((($countones(d) % 2) == 1) != odd);
    endfunction

    function automatic logic ok_exp(logic [7:0] d, logic p, logic odd);
        return ((($countones({d, p}) % 2) == 1) == odd);
    endfunction

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output against the model (called away from the edge)
    task automatic compare();
        check("R2 R3 data to B", {1'b0, b_dout}, {1'b0, ma_d});
        check("R2 R3 data to A", {1'b0, a_dout}, {1'b0, mb_d});
        check(par_feed ? "R5 parity to B" : "R4 parity to B", {8'd0, b_par_out},
              {8'd0, par_feed ? ma_p : gen_exp(ma_d, odd_mode)});
        check(par_feed ? "R5 parity to A" : "R4 parity to A", {8'd0, a_par_out},
              {8'd0, par_feed ? mb_p : gen_exp(mb_d, odd_mode)});
        check("R6 err_a_n", {8'd0, err_a_n}, {8'd0, ok_exp(ma_d, ma_p, odd_mode)});
        check("R6 err_b_n", {8'd0, err_b_n}, {8'd0, ok_exp(mb_d, mb_p, odd_mode)});
        check("R7 drives", {7'd0, a_drive, b_drive}, {7'd0, ~oe_a_n, ~oe_b_n});
    endtask

    // inputs are already set; one edge passes and the model follows
    task automatic cycle();
        if (!rst_n) begin
            ma_d = 0; ma_p = 0; mb_d = 0; mb_p = 0;
        end else begin
            if (le_a) begin ma_d = a_din; ma_p = a_par_in; end
            if (le_b) begin mb_d = b_din; mb_p = b_par_in; end
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        rst_n = 0;
        repeat (3) @(negedge clk);
        cycle();
        // R1: cleared state
        check("R1 reset b_dout", {1'b0, b_dout}, 9'd0);
        check("R1 reset a_dout", {1'b0, a_dout}, 9'd0);
        check("R1 reset parity", {7'd0, a_par_out, b_par_out}, 9'd0);
        check("R1 reset errors", {7'd0, err_a_n, err_b_n}, 9'd3);
        rst_n = 1;

        // R2: load A with bad even parity, drivers off (R6 with oe disabled)
        a_din = 8'h5A; a_par_in = 1; le_a = 1; oe_a_n = 1; oe_b_n = 1;
        cycle();
        check("R2 load to B", {1'b0, b_dout}, 9'h05A);
        check("R6 error with drivers off", {8'd0, err_a_n}, 9'd0);
        check("R8 B-side untouched", {1'b0, a_dout}, 9'd0);

        // R3: hold with new input
        le_a = 0; a_din = 8'hC3; a_par_in = 0;
        cycle();
        check("R3 hold", {1'b0, b_dout}, 9'h05A);

        // R9: sense flip without a capture-relevant edge content change
        odd_mode = 1;
        #1;
        check("R9 error follows sense", {8'd0, err_a_n}, 9'd1);
        check("R9 parity follows sense", {8'd0, b_par_out}, {8'd0, gen_exp(8'h5A, 1'b1)});
        par_feed = 1;
        #1;
        check("R9 feed select immediate", {8'd0, b_par_out}, 9'd1);
        cycle();

        // R8: load B only, A-side word must stay
        le_b = 1; b_din = 8'hFF; b_par_in = 0;
        cycle();
        check("R8 A-side kept", {ma_p, b_dout}, {1'b1, 8'h5A});
        check("R8 err_a_n kept", {8'd0, err_a_n}, 9'd1);
        le_b = 0;

        // random mix
        for (int i = 0; i < 400; i++) begin
            le_a     = ($urandom % 2) == 0;
            le_b     = ($urandom % 2) == 0;
            par_feed = $urandom % 2;
            odd_mode = $urandom % 2;
            oe_a_n   = $urandom % 2;
            oe_b_n   = $urandom % 2;
            a_din    = 8'($urandom);
            b_din    = 8'($urandom);
            a_par_in = $urandom % 2;
            b_par_in = $urandom % 2;
            rst_n    = ($urandom % 64) != 0;
            cycle();
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule